// File: doc/BRIEF.md
# Packet Memory Request Coalescer

This block sits between a four-lane SIMD thread packet and one memory port. All lanes of a packet run the same instruction in lockstep, so one memory operation arrives as a lane-enable mask and one address per lane. The block compares the addresses of the enabled lanes and sends each distinct address to memory once. A packet whose lanes are coherent costs one memory transaction. A packet whose lanes are fully divergent costs one transaction per lane, and nothing is added on top of that.

Memory returns responses in the order the requests were issued. Each returned word is copied into every enabled lane that asked for that address. When the last response has been written, the block offers the whole packet of lane data as one completion. Each side of the block has its own valid/ready handshake. The block holds one packet at a time.

Top module: `pktCoalescer`

## Requirements
- R1: After a packet is accepted, inReady stays low until the completion for that packet has been taken (outValid and outReady high on the same edge).
- R2: The number of memory requests issued for a packet equals the number of distinct addresses among its enabled lanes (mask bit i enables lane i).
- R3: Requests are issued in ascending order of the lowest-numbered enabled lane that carries each distinct address.
- R4: When every enabled lane carries the same address, exactly one request is issued.
- R5: With memReqReady held high and each response given on the cycle after its request, a packet with N>0 distinct addresses has outValid high N+2 cycles after the cycle in which it was accepted.
- R6: A lane whose mask bit is 0 adds no request, whatever its address, and its field of outData is zero.
- R7: The outData field of each enabled lane (bits i*DATA_W and up) holds the response data returned for that lane's address.
- R8: A packet with an all-zero mask issues no request and has outValid high on the cycle after acceptance.
- R9: While outValid is high and outReady is low, outValid stays high and outData does not change.
- R10: While memReqValid is high and memReqReady is low, memReqValid stays high and memReqAddr does not change.
- R11: During and directly after reset, inReady is high and outValid and memReqValid are low.
- R12: memRspReady is high only while at least one issued request has not yet been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Packet operation offered |
| inReady | output | 1 | Block can take a packet |
| inMask | input | LANES | Lane enables, bit i for lane i |
| inAddr | input | LANES*ADDR_W | Lane addresses, lane i at bits i*ADDR_W |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory takes the request |
| memReqAddr | output | ADDR_W | Request address |
| memRspValid | input | 1 | Memory response valid, in request order |
| memRspReady | output | 1 | Block takes the response |
| memRspData | input | DATA_W | Response data |
| outValid | output | 1 | Packet completion valid |
| outReady | input | 1 | Consumer takes the completion |
| outData | output | LANES*DATA_W | Lane data, lane i at bits i*DATA_W |

## Verification
A wrong leader pointer or a wrong duplicate flag shows up at the memory port first. There is an extra or a missing request, or the address order is wrong, on the cycle that request would have been offered. It then shows up at completion as a lane holding another address's data. A pending mask that does not clear, or clears early, shows up as a completion that never comes or comes too soon. The completion latency fixed by R5 catches that within a few cycles. A state machine stuck in a busy state shows at once as inReady staying low.

// File: rtl/coalPkg.sv
package coalPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } coalState_t;

  typedef struct packed {
    logic load;   // latch a new packet
    logic issue;  // current request taken by memory
    logic rsp;    // response taken from memory
  } coalStrobe_t;

endpackage

// File: rtl/coalDatapath.sv
module coalDatapath
  import coalPkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  coalStrobe_t              strobe,
  input  logic [LANES-1:0]         inMask,
  input  logic [LANES*ADDR_W-1:0]  inAddr,
  input  logic [DATA_W-1:0]        memRspData,
  output logic [ADDR_W-1:0]        issueAddr,
  output logic                     issueAny,
  output logic                     outstandingAny,
  output logic                     lastRsp,
  output logic [LANES*DATA_W-1:0]  outData
);

  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  // equality matrix between lane addresses of the offered packet
  logic [LANES-1:0] eqM [LANES];
  for (genvar gi = 0; gi < LANES; gi++) begin : g_row
    for (genvar gj = 0; gj < LANES; gj++) begin : g_col
      assign eqM[gi][gj] = (inAddr[gi*ADDR_W +: ADDR_W] == inAddr[gj*ADDR_W +: ADDR_W]);
    end
  end

  // leader pointer: lowest enabled lane sharing the address
  logic [IDX_W-1:0] leadNext [LANES];
  logic [LANES-1:0] isLead;
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      leadNext[i] = IDX_W'(i);
      isLead[i]   = inMask[i];
      for (int j = i - 1; j >= 0; j--) begin
        if (inMask[j] && eqM[i][j]) begin
          leadNext[i] = IDX_W'(j);
          isLead[i]   = 1'b0;
        end
      end
    end
  end

  logic [ADDR_W-1:0] addrQ   [LANES];
  logic [IDX_W-1:0]  leaderQ [LANES];
  logic [DATA_W-1:0] dataQ   [LANES];
  logic [LANES-1:0]  maskQ;
  logic [LANES-1:0]  issuePend;
  logic [LANES-1:0]  rspPend;

  // lowest set bit selection for issue and response order
  logic [LANES-1:0] issueOh, rspOh;
  logic [IDX_W-1:0] issueIdx, rspIdx;
  assign issueOh = issuePend & (~issuePend + 1'b1);
  assign rspOh   = rspPend & (~rspPend + 1'b1);

  always_comb begin
    issueIdx = '0;
    rspIdx   = '0;
    for (int i = 0; i < LANES; i++) begin
      if (issueOh[i]) issueIdx = IDX_W'(i);
      if (rspOh[i])   rspIdx   = IDX_W'(i);
    end
  end

  assign issueAddr      = addrQ[issueIdx];
  assign issueAny       = |issuePend;
  assign outstandingAny = |(rspPend & ~issuePend);
  assign lastRsp        = (rspPend == rspOh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ     <= '0;
      issuePend <= '0;
      rspPend   <= '0;
      for (int i = 0; i < LANES; i++) begin
        addrQ[i]   <= '0;
        leaderQ[i] <= '0;
        dataQ[i]   <= '0;
      end
    end else if (strobe.load) begin
      maskQ     <= inMask;
      issuePend <= isLead;
      rspPend   <= isLead;
      for (int i = 0; i < LANES; i++) begin
        addrQ[i]   <= inAddr[i*ADDR_W +: ADDR_W];
        leaderQ[i] <= leadNext[i];
        dataQ[i]   <= '0;
      end
    end else begin
      if (strobe.issue) issuePend <= issuePend & ~issueOh;
      if (strobe.rsp) begin
        rspPend <= rspPend & ~rspOh;
        for (int k = 0; k < LANES; k++) begin
          if (maskQ[k] && (leaderQ[k] == rspIdx)) dataQ[k] <= memRspData;
        end
      end
    end
  end

  for (genvar go = 0; go < LANES; go++) begin : g_out
    assign outData[go*DATA_W +: DATA_W] = dataQ[go];
  end

endmodule

// File: rtl/coalControl.sv
module coalControl
  import coalPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inMaskZero,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        outReady,
  input  logic        issueAny,
  input  logic        outstandingAny,
  input  logic        lastRsp,
  output logic        inReady,
  output logic        memReqValid,
  output logic        memRspReady,
  output logic        outValid,
  output coalStrobe_t strobe
);

  coalState_t state, stateNext;

  assign inReady     = (state == ST_IDLE);
  assign memReqValid = (state == ST_RUN) && issueAny;
  assign memRspReady = (state == ST_RUN) && outstandingAny;
  assign outValid    = (state == ST_DONE);

  always_comb begin
    strobe.load  = inReady && inValid;
    strobe.issue = memReqValid && memReqReady;
    strobe.rsp   = memRspReady && memRspValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobe.load) stateNext = inMaskZero ? ST_DONE : ST_RUN;
      ST_RUN:  if (strobe.rsp && lastRsp) stateNext = ST_DONE;
      ST_DONE: if (outReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/pktCoalescer.sv
module pktCoalescer
  import coalPkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [LANES-1:0]        inMask,
  input  logic [LANES*ADDR_W-1:0] inAddr,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memRspValid,
  output logic                    memRspReady,
  input  logic [DATA_W-1:0]       memRspData,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [LANES*DATA_W-1:0] outData
);

  coalStrobe_t strobe;
  logic issueAny, outstandingAny, lastRsp;

  coalControl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .inValid        (inValid),
    .inMaskZero     (inMask == '0),
    .memReqReady    (memReqReady),
    .memRspValid    (memRspValid),
    .outReady       (outReady),
    .issueAny       (issueAny),
    .outstandingAny (outstandingAny),
    .lastRsp        (lastRsp),
    .inReady        (inReady),
    .memReqValid    (memReqValid),
    .memRspReady    (memRspReady),
    .outValid       (outValid),
    .strobe         (strobe)
  );

  coalDatapath #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .inMask         (inMask),
    .inAddr         (inAddr),
    .memRspData     (memRspData),
    .issueAddr      (memReqAddr),
    .issueAny       (issueAny),
    .outstandingAny (outstandingAny),
    .lastRsp        (lastRsp),
    .outData        (outData)
  );

endmodule

// File: rtl/coalChecker.sv
module coalChecker #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inReady,
  input logic [LANES-1:0]        inMask,
  input logic [LANES*ADDR_W-1:0] inAddr,
  input logic                    memReqValid,
  input logic                    memReqReady,
  input logic [ADDR_W-1:0]       memReqAddr,
  input logic                    memRspValid,
  input logic                    memRspReady,
  input logic [DATA_W-1:0]       memRspData,
  input logic                    outValid,
  input logic                    outReady,
  input logic [LANES*DATA_W-1:0] outData
);

  localparam int CNT_W = $clog2(LANES + 1) + 1;

  logic [LANES-1:0]        latMask;
  logic [LANES*ADDR_W-1:0] latAddr;
  logic [CNT_W-1:0]        reqCnt, openCnt, expCnt;

  // independent count of distinct enabled addresses
  always_comb begin
    expCnt = '0;
    for (int i = 0; i < LANES; i++) begin
      logic dup;
      dup = 1'b0;
      for (int j = 0; j < i; j++)
        if (latMask[j] && latAddr[j*ADDR_W +: ADDR_W] == latAddr[i*ADDR_W +: ADDR_W]) dup = 1'b1;
      if (latMask[i] && !dup) expCnt = expCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latMask <= '0;
      latAddr <= '0;
      reqCnt  <= '0;
      openCnt <= '0;
    end else begin
      if (inValid && inReady) begin
        latMask <= inMask;
        latAddr <= inAddr;
        reqCnt  <= '0;
      end else if (memReqValid && memReqReady) begin
        reqCnt <= reqCnt + 1'b1;
      end
      openCnt <= openCnt + CNT_W'(memReqValid && memReqReady) - CNT_W'(memRspValid && memRspReady);
    end
  end

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || memReqValid || memRspReady) |-> !inReady);

  assert_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (reqCnt == expCnt));

  assert_no_excess_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (reqCnt < expCnt));

  assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inMask == '0) |=> (outValid && !memReqValid));

  assert_hold_out_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  assert_rsp_gate_R12: assert property (@(posedge clk) disable iff (!rstN)
    memRspReady |-> (openCnt != '0));

endmodule

bind pktCoalescer coalChecker #(
  .LANES  (LANES),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/pktCoalescer_bench.sv
`timescale 1ns/1ps
module pktCoalescer_bench;

  localparam int LANES = 4;
  localparam int AW    = 32;
  localparam int DW    = 32;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 inValid;
  logic                 inReady;
  logic [LANES-1:0]     inMask;
  logic [LANES*AW-1:0]  inAddr;
  logic                 memReqValid;
  logic                 memReqReady;
  logic [AW-1:0]        memReqAddr;
  logic                 memRspValid;
  logic                 memRspReady;
  logic [DW-1:0]        memRspData;
  logic                 outValid;
  logic                 outReady;
  logic [LANES*DW-1:0]  outData;

  always #10 clk = ~clk;

  pktCoalescer #(.LANES(LANES), .ADDR_W(AW), .DATA_W(DW)) u_pktCoalescer (.*);

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [AW-1:0] memQ [16];
  int qHead = 0, qTail = 0, qCnt = 0;

  function automatic logic [DW-1:0] memFn(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h0101};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runPacket(input logic [LANES-1:0] m, input logic [AW-1:0] a [LANES],
                           input bit stress);
    logic [AW-1:0] expAddr [LANES];
    int expN = 0;
    bit accepted = 1'b0, done = 1'b0, latSeen = 1'b0, spurious = 1'b0, busyOk = 1'b1;
    int reqSeen = 0, acceptCyc = 0, startCyc;
    bit prevOutStall = 1'b0, prevReqStall = 1'b0;
    logic [LANES*DW-1:0] prevData = '0, got = '0;
    logic [AW-1:0] prevReq = '0;
    bit allSame = 1'b1;

    for (int i = 0; i < LANES; i++) begin
      bit dup = 1'b0;
      for (int j = 0; j < i; j++) if (m[j] && a[j] == a[i]) dup = 1'b1;
      if (m[i] && !dup) begin expAddr[expN] = a[i]; expN++; end
      for (int j = 0; j < LANES; j++) if (m[i] && m[j] && a[i] != a[j]) allSame = 1'b0;
    end

    startCyc = cyc;
    while (!done) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      inValid = !accepted;
      inMask  = m;
      for (int i = 0; i < LANES; i++) inAddr[i*AW +: AW] = a[i];
      memReqReady = stress ? (lfsr[0] | lfsr[3]) : 1'b1;
      outReady    = stress ? lfsr[5] : 1'b1;
      memRspValid = (qCnt > 0) && (stress ? (lfsr[2] | lfsr[7]) : 1'b1);
      memRspData  = (qCnt > 0) ? memFn(memQ[qHead]) : '0;
      #1;
      if (prevOutStall)
        chk(outValid && outData == prevData, "R9", "held completion", outData[63:0], prevData[63:0]);
      if (prevReqStall)
        chk(memReqValid && memReqAddr == prevReq, "R10", "held request", 64'(memReqAddr), 64'(prevReq));
      if (memRspReady && qCnt == 0) spurious = 1'b1;
      if (accepted && inReady) busyOk = 1'b0;
      if (inValid && inReady) begin accepted = 1'b1; acceptCyc = cyc; end
      if (memReqValid && memReqReady) begin
        if (reqSeen < expN)
          chk(memReqAddr == expAddr[reqSeen], "R3", "request order", 64'(memReqAddr), 64'(expAddr[reqSeen]));
        memQ[qTail] = memReqAddr;
        qTail = (qTail + 1) % 16;
        qCnt++;
        reqSeen++;
      end
      if (memRspValid && memRspReady) begin
        qHead = (qHead + 1) % 16;
        qCnt--;
      end
      if (outValid && !latSeen) begin
        latSeen = 1'b1;
        if (expN == 0)
          chk(cyc - acceptCyc == 1, "R8", "zero-mask latency", 64'(cyc - acceptCyc), 64'd1);
        else if (!stress)
          chk(cyc - acceptCyc == expN + 2, "R5", "completion latency", 64'(cyc - acceptCyc), 64'(expN + 2));
      end
      if (outValid && outReady) begin
        got  = outData;
        done = 1'b1;
        chk(!inReady, "R1", "busy at completion", 64'(inReady), 64'd0);
      end
      prevOutStall = outValid && !outReady;
      prevData     = outData;
      prevReqStall = memReqValid && !memReqReady;
      prevReq      = memReqAddr;
      if (cyc - startCyc > 400) begin
        chk(1'b0, "R2", "packet hung", 64'(reqSeen), 64'(expN));
        done = 1'b1;
      end
    end

    chk(reqSeen == expN, "R2", "request count", 64'(reqSeen), 64'(expN));
    if (m != '0 && allSame)
      chk(reqSeen == 1, "R4", "coherent packet single request", 64'(reqSeen), 64'd1);
    if (m == '0)
      chk(reqSeen == 0, "R8", "zero-mask requests", 64'(reqSeen), 64'd0);
    chk(!spurious, "R12", "response ready without outstanding request", 64'(spurious), 64'd0);
    chk(busyOk, "R1", "accept blocked while busy", 64'(busyOk), 64'd1);
    for (int i = 0; i < LANES; i++) begin
      if (m[i])
        chk(got[i*DW +: DW] == memFn(a[i]), "R7", "lane data", 64'(got[i*DW +: DW]), 64'(memFn(a[i])));
      else
        chk(got[i*DW +: DW] == '0, "R6", "disabled lane data", 64'(got[i*DW +: DW]), 64'd0);
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a [LANES];
    rstN = 1'b0;
    inValid = 1'b0; inMask = '0; inAddr = '0;
    memReqReady = 1'b0; memRspValid = 1'b0; memRspData = '0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    chk(inReady == 1'b1, "R11", "reset inReady", 64'(inReady), 64'd1);
    chk(!outValid && !memReqValid, "R11", "reset outputs idle", 64'({outValid, memReqValid}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady && !outValid && !memReqValid, "R11", "after reset", 64'({inReady, outValid, memReqValid}), 64'b100);

    // exhaustive sweep: every mask with every choice among four addresses per lane
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 256; p++) begin
        for (int i = 0; i < LANES; i++) a[i] = 32'h0000_1000 + 32'((p >> (2 * i)) & 3) * 8;
        runPacket(4'(m), a, 1'b0);
      end
    end

    // back-pressure on every handshake with pseudo-random packets
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int i = 0; i < LANES; i++) a[i] = 32'h0000_2000 + 32'(lfsr[(2 * i) +: 2]) * 16;
      runPacket(lfsr[11:8], a, 1'b1);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule